// File: doc/BRIEF.md
# Real-Time Clock Indexed Register Port with Interrupt Flags

This block is the host-facing register front end of a real-time clock with a 128-byte register space. The host reaches that space through two addresses. A write to the even address loads a 7-bit pointer. A write to the odd address stores a byte at the location the pointer selects. The current pointer is always visible, and so is the contents of the byte it selects. A read strobe tells the block that the host consumed that byte.

The block applies the side effects of writes itself. A write to the second century location is redirected to the primary one. The flag and status locations cannot be written. A control byte written in set mode loses its update-interrupt enable. The block also holds the three interrupt flags, which the update, alarm and periodic timing logic set with single-cycle pulses. From the flags and their enables it drives a registered, active-high interrupt line. Calendar counting and update timing are outside this block.

Top module: `rtc_regport`

## Requirements
- R1: A write with `wr_sel` = 0 loads the pointer with `wr_data[6:0]`; bit 7 is discarded. The new pointer shows on `cur_index` after that clock edge.
- R2: A write with `wr_sel` = 1 to any location other than 0x0B, 0x0C, 0x0D and 0x37 stores `wr_data` unchanged. This covers the time, date and alarm bytes and general storage. `rd_data` shows the stored byte after that clock edge.
- R3: A data write while the pointer is 0x37 stores the byte at 0x32, not at 0x37, and leaves the pointer at 0x32.
- R4: Data writes to the flag byte at 0x0C and to the status byte at 0x0D have no effect. The status byte always reads 0x80.
- R5: A data write to control byte 0x0B with bit 7 (set mode) equal to 1 stores the byte with bit 4 (update-interrupt enable) forced to 0. With bit 7 equal to 0, the byte is stored as written.
- R6: A pulse on `per_set`, `alm_set` or `upd_set` sets bit 6, bit 5 or bit 4 of the flag byte (0x0C), respectively. A set flag stays set until it is cleared.
- R7: Flag-byte bit 7 and `irq` both equal the OR over the three sources of flag AND enable. The enables are control-byte bits 6, 5 and 4, which line up with the flag bits. `irq` is registered and changes on the same edge as the flag or enable that causes the change.
- R8: A control-byte write that enables a source whose flag is already set raises `irq` on that same edge. A write that leaves no enabled source pending lowers it on that edge.
- R9: A read strobe (`rd_en`) while the pointer is 0x0C returns the flags on `rd_data` and then clears all three flags, so `irq` falls at the next edge. A flag pulse in the same cycle as that read survives the clear.
- R10: After a synchronous reset the pointer is 0, all stored bytes and flags are 0, and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Host write strobe |
| wr_sel | input | 1 | Address bit: 0 selects the pointer, 1 selects the data location |
| wr_data | input | 8 | Host write data |
| rd_en | input | 1 | Host read strobe for the byte at the current pointer |
| per_set | input | 1 | Periodic flag set pulse |
| alm_set | input | 1 | Alarm flag set pulse |
| upd_set | input | 1 | Update-ended flag set pulse |
| cur_index | output | 7 | Current pointer value |
| rd_data | output | 8 | Contents of the byte at the current pointer |
| irq | output | 1 | Registered active-high interrupt request |

## Verification
The pointer and every byte it selects are visible on the ports. A wrong pointer, a misdirected store or a bad control-byte mask therefore shows on `cur_index` or `rd_data` within one clock of the faulty write, once the pointer visits that location. A flag that is wrongly held, lost or left uncleared is different. It shows on `irq` only when its enable is set, so the bench also parks the pointer on the flag byte. There a flag fault appears in `rd_data` on the next edge whatever the enables are. An interrupt line that lags by a cycle is caught at the edge where a control write or a flag pulse should have changed it.

// File: rtl/rtc_regport_pkg.sv
package rtc_regport_pkg;

    parameter int RP_IDX_W  = 7;
    parameter int RP_DATA_W = 8;
    parameter int RP_NSRC   = 3;

    localparam logic [RP_IDX_W-1:0] IDX_CTRL_B   = 7'h0B;
    localparam logic [RP_IDX_W-1:0] IDX_FLAGS    = 7'h0C;
    localparam logic [RP_IDX_W-1:0] IDX_STATUS   = 7'h0D;
    localparam logic [RP_IDX_W-1:0] IDX_CENTURY  = 7'h32;
    localparam logic [RP_IDX_W-1:0] IDX_CENT_ALT = 7'h37;

    localparam logic [RP_DATA_W-1:0] STATUS_VALUE = 8'h80;

    // Bit positions inside the control byte; enables line up with flag bits.
    localparam int BIT_SETMODE = 7;
    localparam int BIT_UPD_EN  = 4;
    localparam int SRC_LSB     = 4;

    typedef enum logic [1:0] {
        WR_NONE,
        WR_INDEX,
        WR_DATA
    } wr_kind_e;

    typedef enum logic [1:0] {
        TGT_PLAIN,
        TGT_CTRL,
        TGT_READONLY
    } tgt_kind_e;

    function automatic logic [RP_IDX_W-1:0] resolve_index(input logic [RP_IDX_W-1:0] idx);
        return (idx == IDX_CENT_ALT) ? IDX_CENTURY : idx;
    endfunction

    function automatic tgt_kind_e classify(input logic [RP_IDX_W-1:0] idx);
        if (idx == IDX_FLAGS || idx == IDX_STATUS) return TGT_READONLY;
        if (idx == IDX_CTRL_B)                     return TGT_CTRL;
        return TGT_PLAIN;
    endfunction

    function automatic logic [RP_DATA_W-1:0] mask_ctrl(input logic [RP_DATA_W-1:0] v);
        logic [RP_DATA_W-1:0] r;
        r = v;
        if (v[BIT_SETMODE]) r[BIT_UPD_EN] = 1'b0;
        return r;
    endfunction

endpackage

// File: rtl/rtc_index_ptr.sv
module rtc_index_ptr
    import rtc_regport_pkg::*;
#(
    parameter int IW = RP_IDX_W
) (
    input  logic          clk,
    input  logic          rst,
    input  wr_kind_e      kind,
    input  logic [IW-1:0] load_val,
    output logic [IW-1:0] idx_q,
    output logic [IW-1:0] tgt_idx
);

    logic [IW-1:0] idx_d;

    always_comb begin
        tgt_idx = resolve_index(idx_q);
    end

    always_comb begin
        unique case (kind)
            WR_INDEX: idx_d = load_val;
            WR_DATA:  idx_d = tgt_idx;
            default:  idx_d = idx_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) idx_q <= '0;
        else     idx_q <= idx_d;
    end

endmodule

// File: rtl/rtc_byte_store.sv
module rtc_byte_store
    import rtc_regport_pkg::*;
#(
    parameter int IW = RP_IDX_W,
    parameter int DW = RP_DATA_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [IW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [IW-1:0] raddr,
    output logic [DW-1:0] rdata,
    output logic [DW-1:0] ctrl_b
);

    localparam int DEPTH = 1 << IW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata  = mem[raddr];
    assign ctrl_b = mem[IDX_CTRL_B];

endmodule

// File: rtl/rtc_irq_unit.sv
module rtc_irq_unit
    import rtc_regport_pkg::*;
#(
    parameter int NSRC = RP_NSRC
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NSRC-1:0] set_pulse,
    input  logic            clr,
    input  logic [NSRC-1:0] en_next,
    output logic [NSRC-1:0] flags_q,
    output logic            irq_q
);

    logic [NSRC-1:0] flags_d;
    logic [NSRC-1:0] active_d;

    for (genvar s = 0; s < NSRC; s++) begin : g_src
        always_comb begin
            flags_d[s]  = (flags_q[s] & ~clr) | set_pulse[s];
            active_d[s] = flags_d[s] & en_next[s];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q <= '0;
            irq_q   <= 1'b0;
        end else begin
            flags_q <= flags_d;
            irq_q   <= |active_d;
        end
    end

endmodule

// File: rtl/rtc_regport.sv
module rtc_regport
    import rtc_regport_pkg::*;
#(
    parameter int IW   = RP_IDX_W,
    parameter int DW   = RP_DATA_W,
    parameter int NSRC = RP_NSRC
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic          wr_sel,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_en,
    input  logic          per_set,
    input  logic          alm_set,
    input  logic          upd_set,
    output logic [IW-1:0] cur_index,
    output logic [DW-1:0] rd_data,
    output logic          irq
);

    localparam int SRC_MSB = SRC_LSB + NSRC - 1;
    localparam int PAD_W   = DW - NSRC - 1;

    wr_kind_e        kind;
    tgt_kind_e       tgt_kind;
    logic [IW-1:0]   idx_q;
    logic [IW-1:0]   tgt_idx;
    logic            store_we;
    logic [DW-1:0]   store_wd;
    logic [DW-1:0]   store_rd;
    logic [DW-1:0]   ctrl_b;
    logic [NSRC-1:0] en_next;
    logic [NSRC-1:0] flags_q;
    logic            irq_q;
    logic            flag_clr;

    always_comb begin
        if (!wr_en)      kind = WR_NONE;
        else if (wr_sel) kind = WR_DATA;
        else             kind = WR_INDEX;
    end

    rtc_index_ptr #(.IW(IW)) u_ptr (
        .clk      (clk),
        .rst      (rst),
        .kind     (kind),
        .load_val (wr_data[IW-1:0]),
        .idx_q    (idx_q),
        .tgt_idx  (tgt_idx)
    );

    always_comb begin
        tgt_kind = classify(tgt_idx);
        store_we = (kind == WR_DATA) && (tgt_kind != TGT_READONLY);
        store_wd = (tgt_kind == TGT_CTRL) ? mask_ctrl(wr_data) : wr_data;
        en_next  = (store_we && tgt_kind == TGT_CTRL) ? store_wd[SRC_MSB:SRC_LSB]
                                                      : ctrl_b[SRC_MSB:SRC_LSB];
        flag_clr = rd_en && (idx_q == IDX_FLAGS);
    end

    rtc_byte_store #(.IW(IW), .DW(DW)) u_store (
        .clk    (clk),
        .rst    (rst),
        .we     (store_we),
        .waddr  (tgt_idx),
        .wdata  (store_wd),
        .raddr  (idx_q),
        .rdata  (store_rd),
        .ctrl_b (ctrl_b)
    );

    rtc_irq_unit #(.NSRC(NSRC)) u_irq (
        .clk       (clk),
        .rst       (rst),
        .set_pulse ({per_set, alm_set, upd_set}),
        .clr       (flag_clr),
        .en_next   (en_next),
        .flags_q   (flags_q),
        .irq_q     (irq_q)
    );

    always_comb begin
        if (idx_q == IDX_FLAGS)       rd_data = {irq_q, flags_q, {PAD_W{1'b0}}};
        else if (idx_q == IDX_STATUS) rd_data = STATUS_VALUE;
        else                          rd_data = store_rd;
    end

    assign cur_index = idx_q;
    assign irq       = irq_q;

endmodule

// File: rtl/rtc_regport_chk.sv
module rtc_regport_chk (
    input logic       clk,
    input logic       rst,
    input logic       wr_en,
    input logic       wr_sel,
    input logic [7:0] wr_data,
    input logic       rd_en,
    input logic       per_set,
    input logic       alm_set,
    input logic       upd_set,
    input logic [6:0] idx,
    input logic [7:0] rd_data,
    input logic       irq,
    input logic [2:0] flags,
    input logic [7:0] ctrl_b
);

    logic any_pulse;
    assign any_pulse = per_set | alm_set | upd_set;

    // R1
    idx_load_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wr_sel) |=> (idx == $past(wr_data[6:0])));

    // R2
    plain_store_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel && idx != 7'h0B && idx != 7'h0C && idx != 7'h0D && idx != 7'h37)
        |=> (rd_data == $past(wr_data)));

    // R3
    alias_redirect_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel && idx == 7'h37) |=> (idx == 7'h32 && rd_data == $past(wr_data)));

    // R4
    status_ro_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel && idx == 7'h0D) |=> (rd_data == 8'h80));

    // R4
    flags_ro_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel && idx == 7'h0C && !rd_en && !any_pulse) |=> $stable(rd_data));

    // R5
    setmode_mask_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel && idx == 7'h0B && wr_data[7]) |=> (ctrl_b[7] && !ctrl_b[4]));

    // R6
    flag_set_chk: assert property (@(posedge clk) disable iff (rst)
        any_pulse |=> ((flags & $past({per_set, alm_set, upd_set})) == $past({per_set, alm_set, upd_set})));

    // R7
    irq_consistent_chk: assert property (@(posedge clk) disable iff (rst)
        irq == (|(flags & ctrl_b[6:4])));

    // R9
    read_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_en && idx == 7'h0C && !any_pulse) |=> (flags == 3'b000 && !irq));

    // R10
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (idx == 7'h00 && !irq && flags == 3'b000));

endmodule

bind rtc_regport rtc_regport_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_sel  (wr_sel),
    .wr_data (wr_data),
    .rd_en   (rd_en),
    .per_set (per_set),
    .alm_set (alm_set),
    .upd_set (upd_set),
    .idx     (idx_q),
    .rd_data (rd_data),
    .irq     (irq_q),
    .flags   (flags_q),
    .ctrl_b  (ctrl_b)
);

// File: tb/rtc_regport_tb.sv
module rtc_regport_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic       wr_sel = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       rd_en = 1'b0;
    logic       per_set = 1'b0;
    logic       alm_set = 1'b0;
    logic       upd_set = 1'b0;
    logic [6:0] cur_index;
    logic [7:0] rd_data;
    logic       irq;

    int n_checks = 0;
    int n_fail = 0;
    int cycles = 0;
    bit model_on = 1'b0;
    string tag = "R10";

    always #5 clk = ~clk;

    rtc_regport u_dut (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_sel    (wr_sel),
        .wr_data   (wr_data),
        .rd_en     (rd_en),
        .per_set   (per_set),
        .alm_set   (alm_set),
        .upd_set   (upd_set),
        .cur_index (cur_index),
        .rd_data   (rd_data),
        .irq       (irq)
    );

    // Behavioural reference model
    logic [7:0] ref_mem [128];
    int         ref_idx;
    logic [2:0] ref_fl;
    logic       ref_irq;
    int         m_old;
    int         m_tgt;

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 128; i++) ref_mem[i] = 8'h00;
            ref_idx = 0;
            ref_fl  = 3'b000;
            ref_irq = 1'b0;
        end else begin
            m_old = ref_idx;
            if (wr_en && !wr_sel) begin
                ref_idx = int'(wr_data & 8'h7F);
            end else if (wr_en && wr_sel) begin
                m_tgt = ref_idx;
                if (m_tgt == 55) begin
                    m_tgt = 50;
                    ref_idx = 50;
                end
                if (m_tgt == 11)
                    ref_mem[11] = wr_data[7] ? (wr_data & 8'hEF) : wr_data;
                else if (m_tgt != 12 && m_tgt != 13)
                    ref_mem[m_tgt] = wr_data;
            end
            if (rd_en && m_old == 12) ref_fl = 3'b000;
            ref_fl = ref_fl | {per_set, alm_set, upd_set};
            ref_irq = |(ref_fl & ref_mem[11][6:4]);
        end
    end

    function automatic logic [7:0] ref_view();
        if (ref_idx == 12) return {ref_irq, ref_fl, 4'h0};
        if (ref_idx == 13) return 8'h80;
        return ref_mem[ref_idx];
    endfunction

    task automatic check8(string req, string what, logic [7:0] act, logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%02h expected=%02h", req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (model_on && !rst) begin
            check8(tag, "model idx", {1'b0, cur_index}, 8'(ref_idx));
            check8(tag, "model rd_data", rd_data, ref_view());
            check8(tag, "model irq", {7'h0, irq}, {7'h0, ref_irq});
        end
    end

    task automatic tick();
        @(negedge clk);
        cycles++;
    endtask

    task automatic host_wr(logic sel, logic [7:0] d);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        tick();
        wr_en = 1'b0; wr_sel = 1'b0;
    endtask

    task automatic pulse(logic p, logic a, logic u, logic rd);
        per_set = p; alm_set = a; upd_set = u; rd_en = rd;
        tick();
        per_set = 1'b0; alm_set = 1'b0; upd_set = 1'b0; rd_en = 1'b0;
    endtask

    task automatic finish_run();
        $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin : watchdog
        #1_500_000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual=expired expected=done");
        finish_run();
    end

    initial begin : stim
        tick(); tick();
        rst = 1'b0;
        tick();
        // R10 reset state
        check8("R10", "index", {1'b0, cur_index}, 8'h00);
        check8("R10", "rd_data", rd_data, 8'h00);
        check8("R10", "irq", {7'h0, irq}, 8'h00);
        model_on = 1'b1;

        tag = "R1";
        host_wr(1'b0, 8'hC5);
        check8("R1", "index low 7 bits", {1'b0, cur_index}, 8'h45);

        tag = "R2";
        host_wr(1'b1, 8'hA7);
        check8("R2", "plain store", rd_data, 8'hA7);
        host_wr(1'b0, 8'h05);
        host_wr(1'b1, 8'h3C);
        check8("R2", "hour alarm store", rd_data, 8'h3C);

        tag = "R3";
        host_wr(1'b0, 8'h37);
        host_wr(1'b1, 8'h19);
        check8("R3", "index moved", {1'b0, cur_index}, 8'h32);
        check8("R3", "century byte", rd_data, 8'h19);
        host_wr(1'b0, 8'h37);
        check8("R3", "alt byte untouched", rd_data, 8'h00);

        tag = "R4";
        host_wr(1'b0, 8'h0D);
        host_wr(1'b1, 8'h12);
        check8("R4", "status read", rd_data, 8'h80);
        host_wr(1'b0, 8'h0C);
        host_wr(1'b1, 8'hF0);
        check8("R4", "flag byte write ignored", rd_data, 8'h00);

        tag = "R5";
        host_wr(1'b0, 8'h0B);
        host_wr(1'b1, 8'h9E);
        check8("R5", "set mode masks enable", rd_data, 8'h8E);
        host_wr(1'b1, 8'h1E);
        check8("R5", "no set mode keeps enable", rd_data, 8'h1E);
        host_wr(1'b1, 8'h00);

        tag = "R6";
        pulse(1'b0, 1'b1, 1'b0, 1'b0);
        check8("R6", "irq stays low when disabled", {7'h0, irq}, 8'h00);
        host_wr(1'b0, 8'h0C);
        check8("R6", "alarm flag visible", rd_data, 8'h20);
        host_wr(1'b0, 8'h0B);

        tag = "R8";
        host_wr(1'b1, 8'h20);
        check8("R8", "enable with pending flag", {7'h0, irq}, 8'h01);
        host_wr(1'b1, 8'h00);
        check8("R8", "disable lowers irq", {7'h0, irq}, 8'h00);
        host_wr(1'b1, 8'hA0);
        check8("R8", "set mode plus alarm enable", {7'h0, irq}, 8'h01);

        tag = "R7";
        pulse(1'b0, 1'b0, 1'b1, 1'b0);
        host_wr(1'b0, 8'h0C);
        check8("R7", "flag byte with irq bit", rd_data, 8'hB0);

        tag = "R9";
        pulse(1'b0, 1'b0, 1'b0, 1'b1);
        check8("R9", "flags cleared", rd_data, 8'h00);
        check8("R9", "irq cleared", {7'h0, irq}, 8'h00);
        pulse(1'b1, 1'b0, 1'b0, 1'b1);
        check8("R9", "pulse beats clear", rd_data, 8'h40);

        tag = "R2,R3,R5,R7,R9";
        for (int n = 0; n < 3000; n++) begin
            int pick;
            pick = $urandom_range(0, 9);
            wr_en   = ($urandom_range(0, 1) == 1);
            wr_sel  = ($urandom_range(0, 2) != 0);
            wr_data = 8'($urandom);
            if (wr_en && !wr_sel) begin
                case (pick)
                    0: wr_data = 8'h0B;
                    1: wr_data = 8'h0C;
                    2: wr_data = 8'h8D;
                    3: wr_data = 8'h37;
                    4: wr_data = 8'h32;
                    5: wr_data = 8'h0C;
                    default: ;
                endcase
            end
            rd_en   = ($urandom_range(0, 4) == 0);
            per_set = ($urandom_range(0, 9) == 0);
            alm_set = ($urandom_range(0, 9) == 0);
            upd_set = ($urandom_range(0, 9) == 0);
            tick();
        end
        wr_en = 1'b0; rd_en = 1'b0;
        per_set = 1'b0; alm_set = 1'b0; upd_set = 1'b0;
        tick();
        model_on = 1'b0;
        finish_run();
    end

endmodule